// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the slave-side protocol engine of a byte-wide non-volatile memory that is reached over a two-wire serial bus. It receives the clock and data lines after they have been synchronized into a fast system clock. It detects bus start, repeated start and stop conditions, and it decodes the device select byte against the chip-enable pins. It loads and advances an internal address counter and runs byte and page writes, current-address reads, random reads and sequential reads. The data line is driven only through an active-low open-drain enable.

Programming of the cells is left to a separate page-latch block. This engine sends it one write strobe per accepted data byte, a commit pulse that starts the cell programming cycle, and a read address. The page-latch block returns the read data and a busy flag. While that flag is high the engine ignores the bus, so a master can poll with repeated start and select bytes until it gets an acknowledge. A write-protect input lets the engine accept the select and address bytes while it refuses every data byte.

Top module: `seeprom_slave`

## Requirements
- R1: The block leaves idle only on a start condition (data falls while clock is high), which also serves as a repeated start in the middle of a transfer. A stop condition (data rises while clock is high) returns it to idle with the data line released. Reset leaves the data line released, no strobe or commit asserted, and the address counter at 0.
- R2: The first byte after a start is taken most significant bit first. Bits 7..4 must be 1010 and bit 0 selects read (1) or write (0). With the default 10-bit address, bit 3 must equal chip_en[2] and bits 2..1 become address bits 9..8. On a match the block pulls data low through the ninth clock.
- R3: A select byte that does not match gets no acknowledge, and the block stays silent for all following bytes until the next start.
- R4: In a write, the address byte sets address bits 7..0 and is acknowledged. Each data byte is acknowledged and produces one write strobe that carries the current address and the byte. After the strobe only the low 4 address bits advance, wrapping inside the 16-byte page.
- R5: If write_protect is high at any time from the start to the end of the address byte, select and address are still acknowledged, but every data byte gets no acknowledge and no write strobe, and the following stop gives no commit.
- R6: A commit pulse is produced only by a stop that arrives in the slot right after the acknowledge of an accepted data byte. A stop after a select or address acknowledge, or one bit later, gives no commit.
- R7: While mem_busy is high, a start and the select byte that follows are ignored and get no acknowledge. Once busy has fallen, the same select is acknowledged again.
- R8: A write-mode select with an address, then a repeated start and a read select, outputs the byte at the loaded address, most significant bit first. The data line changes only while the clock is low.
- R9: Every output byte advances the full address counter by one, which wraps from the top address (0x3FF) to 0. A current-address read outputs the byte at the counter.
- R10: A low master acknowledge after an output byte makes the block send the next byte. A high one returns it to idle, and it drives the line no more until the next start.
- R11: Reads work the same with write_protect high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line (the resolved wire) |
| chip_en | input | 3 | Chip-enable pin levels compared against the select byte |
| write_protect | input | 1 | High refuses data bytes of write commands |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| mem_wr_en | output | 1 | One-cycle strobe per accepted data byte |
| mem_wr_addr | output | ADDR_W | Address of the strobed byte |
| mem_wr_data | output | 8 | Strobed data byte |
| mem_commit | output | 1 | One-cycle pulse that starts the programming cycle |
| mem_busy | input | 1 | Programming cycle in progress |
| mem_rd_addr | output | ADDR_W | Current address counter, used as read address |
| mem_rd_data | input | 8 | Array byte at mem_rd_addr |

## Verification
Two decisions share the tenth bit slot after a data acknowledge. The rising clock edge there is already taken as the first bit of a possible next byte, yet a stop while the clock is still high must still fire the commit. The bench sends a stop in exactly that slot and expects one commit. It then repeats the write with one extra bit clocked before the stop and expects the commit count to stay unchanged. Separately, a start that arrives while busy is still high is checked to stay without acknowledge while the busy countdown runs.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Select byte check: type nibble plus the chip-enable bits that are
    // not taken over by high address bits.
    function automatic logic sel_match(input logic [7:0] b,
                                       input logic [2:0] ce,
                                       input int hi_bits);
        logic ok;
        ok = (b[7:4] == DEV_TYPE);
        for (int i = 0; i < 3; i++) begin
            if (i >= hi_bits && b[i+1] != ce[i]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/seeprom_bus_events.sv
module seeprom_bus_events
    import seeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.rise  = ~scl_q & scl_i;
        ev.fall  = scl_q & ~scl_i;
        ev.start = scl_q & scl_i & sda_q & ~sda_i;
        ev.stop  = scl_q & scl_i & ~sda_q & sda_i;
    end

endmodule

// File: rtl/seeprom_addr_ctr.sv
module seeprom_addr_ctr #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_hi,
    input  logic [ADDR_W-1:0] hi_val,
    input  logic              ld_lo,
    input  logic [7:0]        lo_val,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LO_MASK = ADDR_W'(8'hFF);
    localparam logic [ADDR_W-1:0] PG_MASK = ADDR_W'((1 << PAGE_W) - 1);

    logic [ADDR_W-1:0] addr_p1;
    assign addr_p1 = addr + ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (ld_hi) begin
            addr <= (addr & LO_MASK) | (hi_val & ~LO_MASK);
        end else if (ld_lo) begin
            addr <= (addr & ~LO_MASK) | ADDR_W'(lo_val);
        end else if (inc_page) begin
            addr <= (addr & ~PG_MASK) | (addr_p1 & PG_MASK);
        end else if (inc_full) begin
            addr <= addr_p1;
        end
    end

    // R9: full increment wraps at the top address
    p_full_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (inc_full && addr == {ADDR_W{1'b1}}) |=> (addr == '0));

    // R4: page increment never leaves the page
    p_page_hold_r4: assert property (@(posedge clk) disable iff (rst)
        inc_page |=> ((addr & ~PG_MASK) == $past(addr & ~PG_MASK)));

endmodule

// File: rtl/seeprom_proto.sv
module seeprom_proto
    import seeprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              sda_i,
    input  logic [2:0]        chip_en,
    input  logic              write_protect,
    input  logic              mem_busy,
    input  logic [7:0]        mem_rd_data,
    input  logic [ADDR_W-1:0] addr,
    output logic              drv,
    output logic              ctr_ld_hi,
    output logic [ADDR_W-1:0] ctr_hi_val,
    output logic              ctr_ld_lo,
    output logic [7:0]        ctr_lo_val,
    output logic              ctr_inc_page,
    output logic              ctr_inc_full,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    output logic              mem_commit
);
    localparam int HI_W = ADDR_W - 8;

    phase_t     st;
    logic [3:0] bit_cnt;
    logic [7:0] sh;
    logic       in_ack;
    logic       wp_seen;
    logic       data_ok;
    logic       commit_arm;
    logic       tx_first;
    logic       mstr_ack;

    logic byte_end, ack_end, sel_ok, load_tx, busy_ev;

    assign byte_end = ev.fall && !ev.start && !ev.stop && st != ST_IDLE
                      && !in_ack && bit_cnt == 4'd8;
    assign ack_end  = ev.fall && !ev.start && !ev.stop && st != ST_IDLE && in_ack;
    assign sel_ok   = sel_match(sh, chip_en, HI_W);
    assign load_tx  = ack_end && st == ST_RDATA && (tx_first || mstr_ack);
    assign busy_ev  = ev.start && mem_busy;

    // high address bits carried by the select byte, if the array needs them
    generate
        if (HI_W > 0) begin : g_hi_bits
            assign ctr_hi_val = {sh[HI_W:1], 8'h00};
        end else begin : g_no_hi_bits
            assign ctr_hi_val = '0;
        end
    endgenerate

    assign ctr_ld_hi    = byte_end && st == ST_SEL && sel_ok;
    assign ctr_ld_lo    = byte_end && st == ST_ADDR;
    assign ctr_lo_val   = sh;
    assign ctr_inc_page = byte_end && st == ST_WDATA && !wp_seen;
    assign ctr_inc_full = load_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            bit_cnt     <= '0;
            sh          <= '0;
            in_ack      <= 1'b0;
            wp_seen     <= 1'b0;
            data_ok     <= 1'b0;
            commit_arm  <= 1'b0;
            tx_first    <= 1'b0;
            mstr_ack    <= 1'b0;
            drv         <= 1'b0;
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
            mem_commit  <= 1'b0;
        end else begin
            mem_wr_en  <= 1'b0;
            mem_commit <= 1'b0;
            if (st == ST_SEL || st == ST_ADDR) wp_seen <= wp_seen | write_protect;

            if (ev.start) begin
                drv        <= 1'b0;
                in_ack     <= 1'b0;
                bit_cnt    <= '0;
                sh         <= '0;
                data_ok    <= 1'b0;
                commit_arm <= 1'b0;
                tx_first   <= 1'b0;
                mstr_ack   <= 1'b0;
                wp_seen    <= write_protect;
                st         <= busy_ev ? ST_IDLE : ST_SEL;
            end else if (ev.stop) begin
                drv        <= 1'b0;
                in_ack     <= 1'b0;
                st         <= ST_IDLE;
                mem_commit <= commit_arm;
                commit_arm <= 1'b0;
            end else if (st != ST_IDLE) begin
                if (ev.rise) begin
                    if (in_ack) begin
                        if (st == ST_RDATA) mstr_ack <= ~sda_i;
                    end else if (bit_cnt < 4'd8) begin
                        bit_cnt <= bit_cnt + 4'd1;
                        if (st != ST_RDATA) sh <= {sh[6:0], sda_i};
                    end
                end
                if (ev.fall) begin
                    commit_arm <= 1'b0;
                    if (in_ack) begin
                        in_ack  <= 1'b0;
                        bit_cnt <= '0;
                        drv     <= 1'b0;
                        if (st == ST_WDATA) commit_arm <= data_ok;
                        if (st == ST_RDATA) begin
                            tx_first <= 1'b0;
                            if (load_tx) begin
                                sh  <= mem_rd_data;
                                drv <= ~mem_rd_data[7];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end else if (bit_cnt == 4'd8) begin
                        in_ack <= 1'b1;
                        case (st)
                            ST_SEL: begin
                                if (sel_ok) begin
                                    drv <= 1'b1;
                                    if (sh[0]) begin
                                        st       <= ST_RDATA;
                                        tx_first <= 1'b1;
                                    end else begin
                                        st <= ST_ADDR;
                                    end
                                end else begin
                                    in_ack <= 1'b0;
                                    st     <= ST_IDLE;
                                end
                            end
                            ST_ADDR: begin
                                drv     <= 1'b1;
                                data_ok <= 1'b0;
                                st      <= ST_WDATA;
                            end
                            ST_WDATA: begin
                                data_ok <= !wp_seen;
                                drv     <= !wp_seen;
                                if (!wp_seen) begin
                                    mem_wr_en   <= 1'b1;
                                    mem_wr_addr <= addr;
                                    mem_wr_data <= sh;
                                end
                            end
                            default: drv <= 1'b0;
                        endcase
                    end else if (st == ST_RDATA) begin
                        sh  <= {sh[6:0], 1'b0};
                        drv <= ~sh[6];
                    end
                end
            end
        end
    end

    // R7: a start seen while busy leaves the engine idle and silent
    p_busy_deaf_r7: assert property (@(posedge clk) disable iff (rst)
        busy_ev |=> (st == ST_IDLE && !drv));

    // R8: the line is only ever pulled after a clock falling edge
    p_drive_after_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(drv) |-> $past(ev.fall));

    // R6: commit pulses only follow a stop condition
    p_commit_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
        mem_commit |-> $past(ev.stop));

    // R4: write strobes come only from the data phase
    p_wr_from_data_r4: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> $past(st == ST_WDATA));

    // R3: an idle engine never pulls the line
    p_idle_released_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !drv);

endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave
    import seeprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        chip_en,
    input  logic              write_protect,
    output logic              sda_drive_low,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    output logic              mem_commit,
    input  logic              mem_busy,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data
);
    bus_ev_t           ev;
    logic              ld_hi, ld_lo, inc_page, inc_full;
    logic [ADDR_W-1:0] hi_val, addr;
    logic [7:0]        lo_val;

    seeprom_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    seeprom_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .ld_hi    (ld_hi),
        .hi_val   (hi_val),
        .ld_lo    (ld_lo),
        .lo_val   (lo_val),
        .inc_page (inc_page),
        .inc_full (inc_full),
        .addr     (addr)
    );

    seeprom_proto #(.ADDR_W(ADDR_W)) u_proto (
        .clk           (clk),
        .rst           (rst),
        .ev            (ev),
        .sda_i         (sda_i),
        .chip_en       (chip_en),
        .write_protect (write_protect),
        .mem_busy      (mem_busy),
        .mem_rd_data   (mem_rd_data),
        .addr          (addr),
        .drv           (sda_drive_low),
        .ctr_ld_hi     (ld_hi),
        .ctr_hi_val    (hi_val),
        .ctr_ld_lo     (ld_lo),
        .ctr_lo_val    (lo_val),
        .ctr_inc_page  (inc_page),
        .ctr_inc_full  (inc_full),
        .mem_wr_en     (mem_wr_en),
        .mem_wr_addr   (mem_wr_addr),
        .mem_wr_data   (mem_wr_data),
        .mem_commit    (mem_commit)
    );

    assign mem_rd_addr = addr;

endmodule

// File: tb/seeprom_slave_tb.sv
module seeprom_slave_tb;
    localparam int HALF     = 8;
    localparam int BUSY_CYC = 400;
    localparam int WD_CYC   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic [2:0] chip_en = 3'b100;
    logic       wp = 1'b0;
    logic       sda_drive_low, mem_wr_en, mem_commit, mem_busy;
    logic [9:0] mem_wr_addr, mem_rd_addr;
    logic [7:0] mem_wr_data, mem_rd_data;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int commit_cnt = 0;
    int busy_cnt = 0;
    logic [9:0] last_wa;
    logic [7:0] mem [0:1023];
    logic [7:0] pend_d [0:1023];
    logic       pend_v [0:1023];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_drive_low;
    assign mem_busy = (busy_cnt != 0);
    assign mem_rd_data = mem[mem_rd_addr];

    seeprom_slave u_dut (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .chip_en       (chip_en),
        .write_protect (wp),
        .sda_drive_low (sda_drive_low),
        .mem_wr_en     (mem_wr_en),
        .mem_wr_addr   (mem_wr_addr),
        .mem_wr_data   (mem_wr_data),
        .mem_commit    (mem_commit),
        .mem_busy      (mem_busy),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_data   (mem_rd_data)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'(a * 37 + 5);
    endfunction

    // page latch and programming model
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) begin
                mem[i]    <= init_val(i);
                pend_v[i] <= 1'b0;
            end
            busy_cnt <= 0;
        end else begin
            if (mem_wr_en) begin
                pend_d[mem_wr_addr] <= mem_wr_data;
                pend_v[mem_wr_addr] <= 1'b1;
                last_wa <= mem_wr_addr;
                wr_cnt  <= wr_cnt + 1;
            end
            if (mem_commit) begin
                for (int i = 0; i < 1024; i++) begin
                    if (pend_v[i]) mem[i] <= pend_d[i];
                    pend_v[i] <= 1'b0;
                end
                commit_cnt <= commit_cnt + 1;
                busy_cnt   <= BUSY_CYC;
            end else if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(HALF);
        scl = 1'b1;   wt(HALF);
        sda_m = 1'b0; wt(HALF);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(HALF);
        scl = 1'b1;   wt(HALF);
        sda_m = 1'b1; wt(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(HALF);
            scl = 1'b1;   wt(HALF);
            scl = 1'b0;
        end
        sda_m = 1'b1; wt(HALF);
        scl = 1'b1;   wt(HALF / 2);
        ack = ~sda_line;
        wt(HALF / 2);
        scl = 1'b0;
    endtask

    // receive a byte; also reports whether the line changed while clock was high
    task automatic recv_byte(input bit nack, output logic [7:0] d, output bit glitch);
        glitch = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wt(HALF);
            scl = 1'b1;   wt(1);
            d[i] = sda_line;
            for (int k = 1; k < HALF; k++) begin
                wt(1);
                if (sda_line != d[i]) glitch = 1'b1;
            end
            scl = 1'b0;
        end
        sda_m = nack; wt(HALF);
        scl = 1'b1;   wt(HALF);
        scl = 1'b0;
    endtask

    task automatic wait_idle();
        while (mem_busy) wt(1);
        wt(4);
    endtask

    task automatic rand_read(input logic [9:0] a, input logic [7:0] exp, input string req);
        bit ack, g;
        logic [7:0] d;
        bus_start();
        send_byte({4'b1010, 1'b1, a[9:8], 1'b0}, ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte({4'b1010, 1'b1, a[9:8], 1'b1}, ack);
        chk(ack, "R1 read select after repeated start", ack, 1);
        recv_byte(1'b1, d, g);
        chk(d == exp, req, d, exp);
        chk(!g, "R8 data stable while clock high", g, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        chk(!sda_drive_low, "R1 reset line released", sda_drive_low, 0);
        chk(!mem_wr_en && !mem_commit, "R1 reset no strobe", {mem_wr_en, mem_commit}, 0);
        chk(mem_rd_addr == 10'd0, "R1 reset counter", mem_rd_addr, 0);
    endtask

    task automatic t_byte_write();
        bit ack;
        int c0, w0;
        c0 = commit_cnt; w0 = wr_cnt;
        bus_start();
        send_byte(8'hAC, ack);
        chk(ack, "R2 select match ack", ack, 1);
        send_byte(8'h34, ack);
        chk(ack, "R4 address ack", ack, 1);
        send_byte(8'h5A, ack);
        chk(ack, "R4 data ack", ack, 1);
        bus_stop();
        chk(wr_cnt == w0 + 1, "R4 one strobe", wr_cnt, w0 + 1);
        chk(last_wa == 10'h234, "R2 R4 strobe address", last_wa, 10'h234);
        chk(commit_cnt == c0 + 1, "R6 commit on stop after data ack", commit_cnt, c0 + 1);
        // poll while programming runs
        bus_start();
        send_byte(8'hAC, ack);
        chk(!ack, "R7 no ack while busy", ack, 0);
        bus_stop();
        wait_idle();
        bus_start();
        send_byte(8'hAC, ack);
        chk(ack, "R7 ack after busy", ack, 1);
        bus_stop();
        wt(4);
        chk(commit_cnt == c0 + 1, "R6 no commit after select-only stop", commit_cnt, c0 + 1);
        rand_read(10'h234, 8'h5A, "R8 random read of written byte");
    endtask

    task automatic t_page_wrap();
        bit ack;
        bus_start();
        send_byte(8'hA8, ack);
        send_byte(8'h1E, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        chk(last_wa == 10'h01F, "R4 second strobe address", last_wa, 10'h01F);
        send_byte(8'h33, ack);
        chk(last_wa == 10'h010, "R4 page wrap address", last_wa, 10'h010);
        bus_stop();
        wait_idle();
        rand_read(10'h010, 8'h33, "R4 wrapped byte stored");
        rand_read(10'h01F, 8'h22, "R4 page byte stored");
    endtask

    task automatic t_protect();
        bit ack;
        int c0, w0;
        c0 = commit_cnt; w0 = wr_cnt;
        wp = 1'b1;
        bus_start();
        send_byte(8'hA8, ack);
        chk(ack, "R5 select ack under protect", ack, 1);
        send_byte(8'h40, ack);
        chk(ack, "R5 address ack under protect", ack, 1);
        wp = 1'b0;
        send_byte(8'h77, ack);
        chk(!ack, "R5 data refused", ack, 0);
        send_byte(8'h78, ack);
        chk(!ack, "R5 second data refused", ack, 0);
        bus_stop();
        wt(4);
        chk(wr_cnt == w0, "R5 no strobe", wr_cnt, w0);
        chk(commit_cnt == c0, "R5 no commit", commit_cnt, c0);
        wp = 1'b1;
        rand_read(10'h040, init_val(10'h040), "R11 read under protect");
        wp = 1'b0;
    endtask

    task automatic t_mismatch();
        bit ack;
        bus_start();
        send_byte(8'hA4, ack);
        chk(!ack, "R3 enable mismatch no ack", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R3 silent after mismatch", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hB8, ack);
        chk(!ack, "R3 wrong type no ack", ack, 0);
        bus_stop();
    endtask

    task automatic t_seq_wrap();
        bit ack, g;
        logic [7:0] d;
        bus_start();
        send_byte(8'hAE, ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte(8'hAF, ack);
        recv_byte(1'b0, d, g);
        chk(d == init_val(10'h3FF), "R10 first sequential byte", d, init_val(10'h3FF));
        recv_byte(1'b1, d, g);
        chk(d == init_val(0), "R9 counter wrap to zero", d, init_val(0));
        // clock one more byte after the no-acknowledge: line must stay released
        recv_byte(1'b1, d, g);
        chk(d == 8'hFF, "R10 released after no-ack", d, 8'hFF);
        bus_stop();
        bus_start();
        send_byte(8'hA9, ack);
        chk(ack, "R9 current read select ack", ack, 1);
        recv_byte(1'b1, d, g);
        chk(d == init_val(1), "R9 current address read", d, init_val(1));
        bus_stop();
    endtask

    task automatic t_stop_late();
        bit ack;
        int c0;
        c0 = commit_cnt;
        bus_start();
        send_byte(8'hA8, ack);
        send_byte(8'h50, ack);
        send_byte(8'h99, ack);
        sda_m = 1'b1; wt(HALF);
        scl = 1'b1;   wt(HALF);
        scl = 1'b0;
        bus_stop();
        wt(4);
        chk(commit_cnt == c0, "R6 no commit on late stop", commit_cnt, c0);
        chk(!sda_drive_low, "R1 released after stop", sda_drive_low, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        wt(5);
        rst = 1'b0;
        wt(3);
        t_reset();
        t_byte_write();
        t_page_wrap();
        t_protect();
        t_mismatch();
        t_seq_wrap();
        t_stop_late();
        finish_run();
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual=running expected=done");
        finish_run();
    end

endmodule